// File: doc/BRIEF.md
# Port Selection and Address-Match Controller

This controller decides when one device sharing a multi-drop parallel bus takes part in transmit or receive transfers. Each direction has its own clock, reset, enable and clear-request inputs. A single chip-enable input is common to both directions. On every rising edge of its clock, a direction samples these inputs and derives three things: a match state, which means the device is addressed and the clear request is idle; a reset-match state, which means the device is addressed and the clear request is active; and a selected state.

The flag output-enable is high whenever a direction is in match or reset-match. This lets the shared empty/full flags drive the bus only while the device is addressed. A direction becomes selected when it is matched and its enable input falls. It then stays selected until the enable is sampled high again, even if chip enable is withdrawn. While selected, the controller strobes the attached FIFO on every clock in which the FIFO can move a word, and on the receive side it turns on the data-bus drivers. A one-clock clear pulse goes to the FIFO when a reset-match begins.

A continuous-selection mode is armed if chip enable and a direction's enable are both low while that direction's reset is held. The direction then stays selected with no handshake for as long as both inputs remain low. FIFO clearing is blocked while this mode is active.

Top module: `port_select_ctrl`

## Requirements
- R1: While reset is held, and on the first edge after it is released with chip enable high, all flag output-enables, selected outputs, strobes and clear pulses are 0.
- R2: When chip enable (active low) is sampled low and the direction's clear request (active low) is sampled high at a rising edge, the direction's flag output-enable is 1 after that edge. When chip enable is sampled high, it is 0 after that edge.
- R3: When chip enable and the clear request are both sampled low, the flag output-enable is 1 after that edge. It stays 1 only while chip enable stays low, even if the clear request is held low longer.
- R4: A direction becomes selected at the first edge where its enable (active low) is sampled low, its previous sample was high, and the direction was already matched. An enable that was already low when the match arose does not select.
- R5: A selected direction remains selected for as long as its enable is sampled low, including after chip enable goes high. It is deselected at the first edge where its enable is sampled high.
- R6: The transfer strobe is high exactly while the direction is selected and its FIFO is ready: not full for transmit, not empty for receive. The receive data-bus output-enable equals the receive selected output.
- R7: The FIFO clear output pulses high for exactly one clock, at the first edge of each reset-match. This also happens while the direction is selected, and the selection is kept.
- R8: If chip enable and a direction's enable are both low at the edges during that direction's reset, the direction is selected from reset onward and strobes on every ready cycle. This lasts until either input is sampled high. The mode is not entered again before the next reset.
- R9: While continuous selection is active, a reset-match produces no FIFO clear pulse, though the flag output-enable still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-side clock |
| tx_rst_n | input | 1 | Transmit-side synchronous reset, active low |
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive-side synchronous reset, active low |
| ce_n | input | 1 | Shared chip enable, active low |
| tx_en_n | input | 1 | Transmit enable, active low |
| tx_clr_n | input | 1 | Transmit FIFO clear request, active low |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| rx_en_n | input | 1 | Receive enable, active low |
| rx_clr_n | input | 1 | Receive FIFO clear request, active low |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| tx_flag_oe | output | 1 | Drive enable for transmit empty/full flags |
| tx_selected | output | 1 | Transmit direction selected |
| tx_wr_stb | output | 1 | Transmit FIFO write strobe |
| tx_fifo_clear | output | 1 | Transmit FIFO clear pulse |
| rx_flag_oe | output | 1 | Drive enable for receive empty/full flags |
| rx_selected | output | 1 | Receive direction selected |
| rx_data_oe | output | 1 | Drive enable for the receive data bus |
| rx_rd_stb | output | 1 | Receive FIFO read strobe |
| rx_fifo_clear | output | 1 | Receive FIFO clear pulse |

## Verification
A clear pulse and an ongoing selection can occur in the same cycle. This happens when the receive side is selected, its enable is held low, and the clear request is then pulled low while chip enable stays low. The bench checks that the clear output is high for that one edge and that the selected output and the data-bus enable stay high through it and afterwards. A second overlap is a reset-match during continuous selection. Here the flag output-enable must rise while the clear output stays low.

// File: rtl/psel_pkg.sv
package psel_pkg;

  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  typedef struct packed {
    logic flag_oe;
    logic selected;
    logic strobe;
    logic clear;
  } lane_out_t;

  // Addressed with clear request idle.
  function automatic logic f_match(logic ce_n, logic clr_n);
    return !ce_n && clr_n;
  endfunction

  // Addressed with clear request active.
  function automatic logic f_rmatch(logic ce_n, logic clr_n);
    return !ce_n && !clr_n;
  endfunction

  // Falling enable: high at the previous sample, low now.
  function automatic logic f_fall(logic prev_n, logic now_n);
    return prev_n && !now_n;
  endfunction

  // Handshake selection: held while enable low, entered on matched fall.
  function automatic logic f_sel_next(logic sel, logic match,
                                      logic en_prev_n, logic en_n);
    if (sel) return !en_n;
    return match && f_fall(en_prev_n, en_n);
  endfunction

  // Continuous mode survives only while both held signals stay low.
  function automatic logic f_cont_next(logic cont, logic ce_n, logic en_n);
    return cont && !ce_n && !en_n;
  endfunction

endpackage

// File: rtl/psel_match.sv
module psel_match
  import psel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic clr_n,
  input  logic cont_act,
  output logic match_q,
  output logic rmatch_q,
  output logic clear_q
);

  logic rmatch_now;
  logic rmatch_start;

  assign rmatch_now   = f_rmatch(ce_n, clr_n);
  assign rmatch_start = rmatch_now && !rmatch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= 1'b0;
      rmatch_q <= 1'b0;
      clear_q  <= 1'b0;
    end else begin
      match_q  <= f_match(ce_n, clr_n);
      rmatch_q <= rmatch_now;
      clear_q  <= rmatch_start && !cont_act;
    end
  end

endmodule

// File: rtl/psel_select.sv
module psel_select
  import psel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic en_n,
  input  logic match_q,
  input  logic ready,
  output logic hs_sel_q,
  output logic cont_q,
  output logic selected,
  output logic strobe
);

  logic en_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_sel_q  <= 1'b0;
      en_prev_q <= en_n;
      cont_q    <= !ce_n && !en_n;
    end else begin
      hs_sel_q  <= f_sel_next(hs_sel_q, match_q, en_prev_q, en_n);
      en_prev_q <= en_n;
      cont_q    <= f_cont_next(cont_q, ce_n, en_n);
    end
  end

  assign selected = hs_sel_q || cont_q;
  assign strobe   = selected && ready;

endmodule

// File: rtl/psel_lane.sv
module psel_lane
  import psel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      en_n,
  input  logic      clr_n,
  input  logic      ready,
  output lane_out_t lane_o,
  output logic      hs_sel_o,
  output logic      cont_o
);

  logic match_q;
  logic rmatch_q;
  logic clear_q;
  logic hs_sel_q;
  logic cont_q;
  logic selected;
  logic strobe;

  psel_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .clr_n    (clr_n),
    .cont_act (cont_q),
    .match_q  (match_q),
    .rmatch_q (rmatch_q),
    .clear_q  (clear_q)
  );

  psel_select u_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .en_n     (en_n),
    .match_q  (match_q),
    .ready    (ready),
    .hs_sel_q (hs_sel_q),
    .cont_q   (cont_q),
    .selected (selected),
    .strobe   (strobe)
  );

  always_comb begin
    lane_o.flag_oe  = match_q || rmatch_q;
    lane_o.selected = selected;
    lane_o.strobe   = strobe;
    lane_o.clear    = clear_q;
  end

  assign hs_sel_o = hs_sel_q;
  assign cont_o   = cont_q;

endmodule

// File: rtl/port_select_ctrl.sv
module port_select_ctrl
  import psel_pkg::*;
(
  input  logic tx_clk,
  input  logic tx_rst_n,
  input  logic rx_clk,
  input  logic rx_rst_n,
  input  logic ce_n,
  input  logic tx_en_n,
  input  logic tx_clr_n,
  input  logic tx_fifo_full,
  input  logic rx_en_n,
  input  logic rx_clr_n,
  input  logic rx_fifo_empty,
  output logic tx_flag_oe,
  output logic tx_selected,
  output logic tx_wr_stb,
  output logic tx_fifo_clear,
  output logic rx_flag_oe,
  output logic rx_selected,
  output logic rx_data_oe,
  output logic rx_rd_stb,
  output logic rx_fifo_clear
);

  logic [NDIR-1:0] clk_v;
  logic [NDIR-1:0] rst_v;
  logic [NDIR-1:0] en_v;
  logic [NDIR-1:0] clr_v;
  logic [NDIR-1:0] ready_v;
  logic [NDIR-1:0] hs_sel_v;
  logic [NDIR-1:0] cont_v;
  lane_out_t       lane_v [NDIR];

  // Named per-lane event wires for the checker.
  logic [NDIR-1:0] flag_oe_v;
  logic [NDIR-1:0] sel_v;
  logic [NDIR-1:0] stb_v;
  logic [NDIR-1:0] clear_v;

  assign clk_v[DIR_TX]   = tx_clk;
  assign clk_v[DIR_RX]   = rx_clk;
  assign rst_v[DIR_TX]   = tx_rst_n;
  assign rst_v[DIR_RX]   = rx_rst_n;
  assign en_v[DIR_TX]    = tx_en_n;
  assign en_v[DIR_RX]    = rx_en_n;
  assign clr_v[DIR_TX]   = tx_clr_n;
  assign clr_v[DIR_RX]   = rx_clr_n;
  assign ready_v[DIR_TX] = !tx_fifo_full;
  assign ready_v[DIR_RX] = !rx_fifo_empty;

  for (genvar d = 0; d < NDIR; d++) begin : g_lane
    psel_lane u_lane (
      .clk      (clk_v[d]),
      .rst_n    (rst_v[d]),
      .ce_n     (ce_n),
      .en_n     (en_v[d]),
      .clr_n    (clr_v[d]),
      .ready    (ready_v[d]),
      .lane_o   (lane_v[d]),
      .hs_sel_o (hs_sel_v[d]),
      .cont_o   (cont_v[d])
    );
    assign flag_oe_v[d] = lane_v[d].flag_oe;
    assign sel_v[d]     = lane_v[d].selected;
    assign stb_v[d]     = lane_v[d].strobe;
    assign clear_v[d]   = lane_v[d].clear;
  end

  assign tx_flag_oe    = flag_oe_v[DIR_TX];
  assign tx_selected   = sel_v[DIR_TX];
  assign tx_wr_stb     = stb_v[DIR_TX];
  assign tx_fifo_clear = clear_v[DIR_TX];
  assign rx_flag_oe    = flag_oe_v[DIR_RX];
  assign rx_selected   = sel_v[DIR_RX];
  assign rx_data_oe    = sel_v[DIR_RX];
  assign rx_rd_stb     = stb_v[DIR_RX];
  assign rx_fifo_clear = clear_v[DIR_RX];

endmodule

// File: rtl/psel_checker.sv
module psel_checker
  import psel_pkg::*;
(
  input logic            ce_n,
  input logic [NDIR-1:0] clk_v,
  input logic [NDIR-1:0] rst_v,
  input logic [NDIR-1:0] en_v,
  input logic [NDIR-1:0] ready_v,
  input logic [NDIR-1:0] hs_sel_v,
  input logic [NDIR-1:0] cont_v,
  input logic [NDIR-1:0] flag_oe_v,
  input logic [NDIR-1:0] sel_v,
  input logic [NDIR-1:0] stb_v,
  input logic [NDIR-1:0] clear_v
);

  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    // R2, R3: addressed at an edge -> flags driven after it
    p_flag_on_r2: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      !ce_n |=> flag_oe_v[d]);
    // R2, R3: not addressed -> flags released
    p_flag_off_r3: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      ce_n |=> !flag_oe_v[d]);
    // R5: handshake selection held while enable stays low
    p_hold_r5: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      (hs_sel_v[d] && !en_v[d]) |=> hs_sel_v[d]);
    // R5: enable sampled high drops handshake selection
    p_drop_r5: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      (hs_sel_v[d] && en_v[d]) |=> !hs_sel_v[d]);
    // R6: strobe only when selected and FIFO ready
    p_strobe_r6: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      stb_v[d] |-> (sel_v[d] && ready_v[d]));
    // R7: clear pulse is one clock wide
    p_clear_single_r7: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      clear_v[d] |=> !clear_v[d]);
    // R7: clear pulse only during a reset-match, when flags are driven
    p_clear_flag_r7: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      clear_v[d] |-> flag_oe_v[d]);
    // R9: continuous selection blocks the next clear pulse
    p_cont_noclr_r9: assert property (@(posedge clk_v[d]) disable iff (!rst_v[d])
      cont_v[d] |=> !clear_v[d]);
  end

endmodule

bind port_select_ctrl psel_checker u_chk (
  .ce_n      (ce_n),
  .clk_v     (clk_v),
  .rst_v     (rst_v),
  .en_v      (en_v),
  .ready_v   (ready_v),
  .hs_sel_v  (hs_sel_v),
  .cont_v    (cont_v),
  .flag_oe_v (flag_oe_v),
  .sel_v     (sel_v),
  .stb_v     (stb_v),
  .clear_v   (clear_v)
);

// File: tb/port_select_ctrl_bench.sv
`timescale 1ns/1ps
module port_select_ctrl_bench;

  logic tx_clk = 1'b0;
  logic rx_clk = 1'b0;
  logic tx_rst_n, rx_rst_n, ce_n;
  logic tx_en_n, tx_clr_n, tx_fifo_full;
  logic rx_en_n, rx_clr_n, rx_fifo_empty;
  logic tx_flag_oe, tx_selected, tx_wr_stb, tx_fifo_clear;
  logic rx_flag_oe, rx_selected, rx_data_oe, rx_rd_stb, rx_fifo_clear;

  int vectors = 0;
  int errors  = 0;

  // 250 MHz on both sides; receive clock offset by 1 ns.
  always #2 tx_clk = ~tx_clk;
  initial begin
    #1;
    forever #2 rx_clk = ~rx_clk;
  end

  port_select_ctrl u_port_select_ctrl (.*);

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick_rx();
    @(posedge rx_clk);
    @(negedge rx_clk);
  endtask

  task automatic tick_tx();
    @(posedge tx_clk);
    @(negedge tx_clk);
  endtask

  task automatic rx_idle();
    ce_n = 1'b1; rx_en_n = 1'b1; rx_clr_n = 1'b1; rx_fifo_empty = 1'b0;
    tick_rx(); tick_rx();
  endtask

  task automatic t_reset();
    tick_rx(); tick_tx();
    chk("R1", "rx_selected in reset", rx_selected, 1'b0);
    chk("R1", "rx_flag_oe in reset", rx_flag_oe, 1'b0);
    tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    tick_rx(); tick_tx();
    chk("R1", "rx_flag_oe", rx_flag_oe, 1'b0);
    chk("R1", "rx_rd_stb", rx_rd_stb, 1'b0);
    chk("R1", "rx_fifo_clear", rx_fifo_clear, 1'b0);
    chk("R1", "tx_selected", tx_selected, 1'b0);
    chk("R1", "tx_wr_stb", tx_wr_stb, 1'b0);
    chk("R1", "tx_flag_oe", tx_flag_oe, 1'b0);
  endtask

  task automatic t_rx_select();
    rx_idle();
    ce_n = 1'b0; tick_rx();
    chk("R2", "flag_oe on match", rx_flag_oe, 1'b1);
    chk("R4", "no select without enable fall", rx_selected, 1'b0);
    rx_en_n = 1'b0; tick_rx();
    chk("R4", "selected on fall", rx_selected, 1'b1);
    chk("R6", "data_oe", rx_data_oe, 1'b1);
    chk("R6", "rd_stb not empty", rx_rd_stb, 1'b1);
    rx_fifo_empty = 1'b1; #0.5;
    chk("R6", "rd_stb empty", rx_rd_stb, 1'b0);
    rx_fifo_empty = 1'b0;
    ce_n = 1'b1; tick_rx();
    chk("R5", "held after ce high", rx_selected, 1'b1);
    chk("R2", "flag_oe off", rx_flag_oe, 1'b0);
    tick_rx();
    chk("R5", "still held", rx_selected, 1'b1);
    rx_en_n = 1'b1; tick_rx();
    chk("R5", "dropped on enable high", rx_selected, 1'b0);
    chk("R6", "data_oe off", rx_data_oe, 1'b0);
  endtask

  task automatic t_rx_early_enable();
    rx_idle();
    rx_en_n = 1'b0; tick_rx();
    ce_n = 1'b0; tick_rx();
    tick_rx();
    chk("R4", "enable low before match", rx_selected, 1'b0);
    rx_en_n = 1'b1; tick_rx();
    rx_en_n = 1'b0; tick_rx();
    chk("R4", "fresh fall selects", rx_selected, 1'b1);
    rx_en_n = 1'b1; tick_rx();
    ce_n = 1'b1; tick_rx();
  endtask

  task automatic t_rx_reset_match();
    rx_idle();
    ce_n = 1'b0; rx_clr_n = 1'b0; tick_rx();
    chk("R3", "flag_oe on reset-match", rx_flag_oe, 1'b1);
    chk("R7", "clear first cycle", rx_fifo_clear, 1'b1);
    tick_rx();
    chk("R7", "clear second cycle", rx_fifo_clear, 1'b0);
    chk("R3", "flag_oe held", rx_flag_oe, 1'b1);
    ce_n = 1'b1; tick_rx();
    chk("R3", "ends with ce high", rx_flag_oe, 1'b0);
    chk("R7", "no clear", rx_fifo_clear, 1'b0);
    rx_clr_n = 1'b1; tick_rx();
  endtask

  task automatic t_rx_clear_while_selected();
    rx_idle();
    ce_n = 1'b0; tick_rx();
    rx_en_n = 1'b0; tick_rx();
    rx_clr_n = 1'b0; tick_rx();
    chk("R7", "clear while selected", rx_fifo_clear, 1'b1);
    chk("R7", "selection kept", rx_selected, 1'b1);
    chk("R6", "data_oe kept", rx_data_oe, 1'b1);
    tick_rx();
    chk("R7", "clear ends", rx_fifo_clear, 1'b0);
    chk("R5", "still selected", rx_selected, 1'b1);
    rx_en_n = 1'b1; rx_clr_n = 1'b1; tick_rx();
    ce_n = 1'b1; tick_rx();
  endtask

  task automatic t_rx_continuous();
    rx_idle();
    rx_rst_n = 1'b0; ce_n = 1'b0; rx_en_n = 1'b0;
    tick_rx(); tick_rx();
    rx_rst_n = 1'b1; tick_rx();
    chk("R8", "continuous selected", rx_selected, 1'b1);
    chk("R8", "strobe every cycle", rx_rd_stb, 1'b1);
    tick_rx();
    chk("R8", "strobe next cycle", rx_rd_stb, 1'b1);
    rx_clr_n = 1'b0; tick_rx();
    chk("R9", "flag_oe in continuous reset-match", rx_flag_oe, 1'b1);
    chk("R9", "no clear in continuous", rx_fifo_clear, 1'b0);
    tick_rx();
    chk("R9", "still no clear", rx_fifo_clear, 1'b0);
    rx_clr_n = 1'b1; tick_rx();
    ce_n = 1'b1; tick_rx();
    chk("R8", "continuous ends on ce high", rx_selected, 1'b0);
    ce_n = 1'b0; tick_rx(); tick_rx();
    chk("R8", "not re-entered", rx_selected, 1'b0);
    rx_en_n = 1'b1; ce_n = 1'b1; tick_rx();
  endtask

  task automatic t_tx_select();
    ce_n = 1'b1; tx_en_n = 1'b1; tx_clr_n = 1'b1; tx_fifo_full = 1'b0;
    tick_tx(); tick_tx();
    ce_n = 1'b0; tick_tx();
    chk("R2", "tx flag_oe on match", tx_flag_oe, 1'b1);
    tx_en_n = 1'b0; tick_tx();
    chk("R4", "tx selected", tx_selected, 1'b1);
    chk("R6", "tx wr_stb not full", tx_wr_stb, 1'b1);
    tx_fifo_full = 1'b1; #0.5;
    chk("R6", "tx wr_stb full", tx_wr_stb, 1'b0);
    tx_fifo_full = 1'b0;
    tx_en_n = 1'b1; tick_tx();
    chk("R5", "tx dropped", tx_selected, 1'b0);
    tx_clr_n = 1'b0; tick_tx();
    chk("R7", "tx clear pulse", tx_fifo_clear, 1'b1);
    tick_tx();
    chk("R7", "tx clear single", tx_fifo_clear, 1'b0);
    tx_clr_n = 1'b1; ce_n = 1'b1; tick_tx();
    chk("R2", "tx flag_oe off", tx_flag_oe, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge tx_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tx_rst_n = 1'b0; rx_rst_n = 1'b0; ce_n = 1'b1;
    tx_en_n = 1'b1; tx_clr_n = 1'b1; tx_fifo_full = 1'b0;
    rx_en_n = 1'b1; rx_clr_n = 1'b1; rx_fifo_empty = 1'b0;
    t_reset();
    t_rx_select();
    t_rx_early_enable();
    t_rx_reset_match();
    t_rx_clear_while_selected();
    t_rx_continuous();
    t_tx_select();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule